// File: doc/BRIEF.md
# Granule Tag Span Checker

The block decides whether a memory access may proceed by comparing the 4-bit tag carried with its pointer against the allocation tag of every 16-byte granule the access touches. A request gives the start address, the access size minus one, a write flag, a check enable, a match-all bypass and the pointer tag. The block fetches packed tag bytes from a synchronous tag memory, with one read per byte and two granule tags per byte. It then reports pass or fail, how many leading granules matched, and the address of the first failing byte range.

Each check starts with a valid/ready handshake. The block takes a new request only while idle. Once a request finishes, the result is flagged by a one-cycle `res_valid` pulse, and the result fields hold their values until the next request is accepted. A disabled check or an applicable match-all bypass finishes without touching tag memory.

Top module: `tag_span_checker`

## Requirements
- R1: The number of granules checked is ((start address bits 3:0 + size-minus-one) >> 4) + 1, and a fully matching access reports exactly that count.
- R2: Tag byte address is the granule index shifted right by one (start address bits AW-1:5 for the first byte). An even granule's tag sits in bits 3:0 and an odd granule's tag in bits 7:4. Exactly one read is issued per tag byte visited.
- R3: When start address bit 4 is 1, the walk begins on the high nibble of the first byte and then moves to the low nibble of the following byte.
- R4: The walk stops at the first granule whose tag differs from the pointer tag. The reported count is the number of leading matches, and pass is 1 exactly when that count equals the granule count.
- R5: A mismatch in the first granule reports the unrounded start address as the fault address.
- R6: A mismatch in any later granule reports (start address rounded down to 16) + 16 x count as the fault address.
- R7: With the check enable low, the result is pass with count 0 and fault address equal to the start address, and no tag read is issued.
- R8: With the match-all bypass high, the result is the same as in R7 and no tag read is issued.
- R9: `req_ready` is high only while idle. `res_valid` pulses for one cycle per request, and pass, count, fault address and write echo then hold until the next accepted request.
- R10: The write flag does not change the check outcome. It is echoed on `res_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_addr | input | AW | Access start address |
| req_size_m1 | input | SW | Access size in bytes minus one |
| req_write | input | 1 | Access is a store |
| req_check_en | input | 1 | Tag checking enabled |
| req_match_all | input | 1 | Pointer tag matches everything, skip check |
| req_tag | input | 4 | Pointer tag |
| tm_rd_en | output | 1 | Tag memory read strobe |
| tm_addr | output | AW-5 | Tag memory byte address |
| tm_rd_data | input | 8 | Tag byte, valid one cycle after the read strobe |
| res_valid | output | 1 | One-cycle result pulse |
| res_pass | output | 1 | Access passed |
| res_count | output | CW | Leading matching granules |
| res_fault_addr | output | AW | First failing address, or start address |
| res_write | output | 1 | Echo of the write flag |

## Verification
Aligned single-granule accesses and multi-granule spans starting on an even granule test the basic count and the one-read-per-byte fetch. Spans starting on an odd granule and spans ending on a low nibble test nibble selection at both ends. Mismatches are placed on the first granule, on a later high nibble and on a later low nibble, which separates the first-granule fault rule from the rounded-base rule and shows where the pair compare stops. A repeated access with the write flag flipped, disabled and bypassed requests with a deliberately wrong tag, and a sweep against sparsely corrupted tag memory complete the set. The sweep compares every field and the read count with a reference walk.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int GRAN_LOG2 = 4;
   localparam int TAG_W     = 4;

   typedef enum logic [1:0] {
      TS_IDLE  = 2'd0,
      TS_FETCH = 2'd1,
      TS_CMP   = 2'd2
   } tsc_state_e;
endpackage

// File: rtl/tsc_span_calc.sv
module tsc_span_calc #(
   parameter int AW = 32,
   parameter int SW = 8,
   parameter int CW = 5
) (
   input  logic [AW-1:0] addr,
   input  logic [SW-1:0] size_m1,
   output logic [CW-1:0] tag_count,
   output logic          start_odd,
   output logic [AW-6:0] byte_addr
);
   localparam int SUM_W = SW + 1;

   logic [SUM_W-1:0] in_gran_end;

   always_comb begin
      in_gran_end = SUM_W'(addr[3:0]) + SUM_W'(size_m1);
      tag_count   = CW'(in_gran_end >> 4) + CW'(1);
      start_odd   = addr[4];
      byte_addr   = addr[AW-1:5];
   end
endmodule

// File: rtl/tsc_nibble_cmp.sv
module tsc_nibble_cmp (
   input  logic [7:0] tag_byte,
   input  logic [3:0] ptr_tag,
   output logic [1:0] nib_ok
);
   logic [7:0] diff;

   assign diff = tag_byte ^ {ptr_tag, ptr_tag};

   for (genvar i = 0; i < 2; i++) begin : g_nib
      assign nib_ok[i] = ~|diff[4*i +: 4];
   end
endmodule

// File: rtl/tsc_fault_calc.sv
module tsc_fault_calc #(
   parameter int AW = 32,
   parameter int CW = 5
) (
   input  logic [AW-1:0] start_addr,
   input  logic [CW-1:0] match_cnt,
   output logic [AW-1:0] fault_addr
);
   logic [AW-1:0] base;

   always_comb begin
      base = {start_addr[AW-1:4], 4'b0000};
      if (match_cnt == '0)
         fault_addr = start_addr;
      else
         fault_addr = base + (AW'(match_cnt) << 4);
   end
endmodule

// File: rtl/tag_span_checker.sv
module tag_span_checker
   import tsc_pkg::*;
#(
   parameter int AW = 32,
   parameter int SW = 8,
   localparam int MAXT = (((1 << SW) + 14) >> 4) + 1,
   localparam int CW = $clog2(MAXT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [SW-1:0] req_size_m1,
   input  logic          req_write,
   input  logic          req_check_en,
   input  logic          req_match_all,
   input  logic [3:0]    req_tag,
   output logic          tm_rd_en,
   output logic [AW-6:0] tm_addr,
   input  logic [7:0]    tm_rd_data,
   output logic          res_valid,
   output logic          res_pass,
   output logic [CW-1:0] res_count,
   output logic [AW-1:0] res_fault_addr,
   output logic          res_write
);
   if (AW < 8) begin : g_bad_aw
      $error("tag_span_checker: AW must be at least 8");
   end
   if (SW < 1 || SW > 16) begin : g_bad_sw
      $error("tag_span_checker: SW must lie in 1..16");
   end

   tsc_state_e    state_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] tcnt_q, cnt_q;
   logic          nib_q;
   logic [AW-6:0] baddr_q;
   logic [3:0]    tag_q;
   logic          chk_q;

   logic          accept, bypass_now;
   logic [CW-1:0] span_cnt;
   logic          span_odd;
   logic [AW-6:0] span_baddr;
   logic [1:0]    nib_ok;
   logic [CW-1:0] rem, cnt_nx;
   logic          pair, first_ok, mis, fin;
   logic [1:0]    add;
   logic [AW-1:0] walk_fault;

   assign req_ready  = (state_q == TS_IDLE);
   assign accept     = req_valid && req_ready;
   assign bypass_now = !req_check_en || req_match_all;
   assign tm_rd_en   = (state_q == TS_FETCH);
   assign tm_addr    = baddr_q;

   tsc_span_calc #(.AW(AW), .SW(SW), .CW(CW)) i_span (
      .addr      (req_addr),
      .size_m1   (req_size_m1),
      .tag_count (span_cnt),
      .start_odd (span_odd),
      .byte_addr (span_baddr)
   );

   tsc_nibble_cmp i_cmp (
      .tag_byte (tm_rd_data),
      .ptr_tag  (tag_q),
      .nib_ok   (nib_ok)
   );

   tsc_fault_calc #(.AW(AW), .CW(CW)) i_fault (
      .start_addr (addr_q),
      .match_cnt  (cnt_nx),
      .fault_addr (walk_fault)
   );

   // Pair compare: from a low nibble both nibbles of the byte may be consumed.
   always_comb begin
      rem      = tcnt_q - cnt_q;
      pair     = !nib_q && (rem >= CW'(2));
      first_ok = nib_q ? nib_ok[1] : nib_ok[0];
      if (!first_ok)
         add = 2'd0;
      else if (pair && nib_ok[1])
         add = 2'd2;
      else
         add = 2'd1;
      mis    = !first_ok || (pair && !nib_ok[1]);
      cnt_nx = cnt_q + CW'(add);
      fin    = mis || (cnt_nx == tcnt_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q        <= TS_IDLE;
         addr_q         <= '0;
         tcnt_q         <= '0;
         cnt_q          <= '0;
         nib_q          <= 1'b0;
         baddr_q        <= '0;
         tag_q          <= '0;
         chk_q          <= 1'b0;
         res_valid      <= 1'b0;
         res_pass       <= 1'b0;
         res_count      <= '0;
         res_fault_addr <= '0;
         res_write      <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         unique case (state_q)
            TS_IDLE: begin
               if (accept) begin
                  addr_q    <= req_addr;
                  tag_q     <= req_tag;
                  res_write <= req_write;
                  if (bypass_now) begin
                     chk_q          <= 1'b0;
                     res_valid      <= 1'b1;
                     res_pass       <= 1'b1;
                     res_count      <= '0;
                     res_fault_addr <= req_addr;
                  end else begin
                     chk_q   <= 1'b1;
                     tcnt_q  <= span_cnt;
                     cnt_q   <= '0;
                     nib_q   <= span_odd;
                     baddr_q <= span_baddr;
                     state_q <= TS_FETCH;
                  end
               end
            end
            TS_FETCH: state_q <= TS_CMP;
            TS_CMP: begin
               cnt_q <= cnt_nx;
               if (fin) begin
                  res_valid      <= 1'b1;
                  res_pass       <= !mis;
                  res_count      <= cnt_nx;
                  res_fault_addr <= walk_fault;
                  state_q        <= TS_IDLE;
               end else begin
                  nib_q   <= 1'b0;
                  baddr_q <= baddr_q + 1'b1;
                  state_q <= TS_FETCH;
               end
            end
            default: state_q <= TS_IDLE;
         endcase
      end
   end

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> ($stable(res_pass) && $stable(res_count) &&
                                     $stable(res_fault_addr) && $stable(res_write) && !res_valid)); // R9
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R9
   AST_PASS_IFF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && chk_q) |-> (res_pass == (res_count == tcnt_q))); // R4
   AST_FIRST_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_pass && res_count == '0) |-> (res_fault_addr == addr_q)); // R5
   AST_NO_READ_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && bypass_now) |=> !tm_rd_en); // R7
   AST_READ_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      tm_rd_en |-> (cnt_q < tcnt_q)); // R1
endmodule

// File: tb/test_tag_span_checker.sv
`timescale 1ns/1ps
module test_tag_span_checker;
   localparam int AW = 32;
   localparam int SW = 8;
   localparam int CW = 5;

   typedef struct {
      logic          pass;
      logic [CW-1:0] count;
      logic [AW-1:0] fault;
      logic          wr;
      int            reads;
      string         rq;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_size_m1 = '0;
   logic          req_write = 1'b0;
   logic          req_check_en = 1'b0;
   logic          req_match_all = 1'b0;
   logic [3:0]    req_tag = '0;
   logic          tm_rd_en;
   logic [AW-6:0] tm_addr;
   logic [7:0]    tm_rd_data = '0;
   logic          res_valid;
   logic          res_pass;
   logic [CW-1:0] res_count;
   logic [AW-1:0] res_fault_addr;
   logic          res_write;

   logic [7:0] tmem [64];
   exp_t       sb_q[$];
   exp_t       last_exp;
   int n_chk = 0, n_fail = 0, n_sent = 0, n_seen = 0, rd_cnt = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tag_span_checker #(.AW(AW), .SW(SW)) i_tag_span_checker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size_m1(req_size_m1), .req_write(req_write),
      .req_check_en(req_check_en), .req_match_all(req_match_all), .req_tag(req_tag),
      .tm_rd_en(tm_rd_en), .tm_addr(tm_addr), .tm_rd_data(tm_rd_data),
      .res_valid(res_valid), .res_pass(res_pass), .res_count(res_count),
      .res_fault_addr(res_fault_addr), .res_write(res_write)
   );

   // Tag memory model: one-cycle read latency.
   always @(posedge clk) begin
      if (tm_rd_en) begin
         tm_rd_data <= tmem[tm_addr[5:0]];
         rd_cnt = rd_cnt + 1;
      end
   end

   task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic exp_t ref_walk(logic [AW-1:0] a, int sz, bit wr, bit en,
                                     bit all, logic [3:0] t);
      exp_t e;
      int g0, tc, n, lastg;
      logic [7:0] b;
      logic [3:0] nb;
      e.wr = wr;
      if (!en || all) begin
         e.pass = 1'b1; e.count = '0; e.fault = a; e.reads = 0;
         e.rq = en ? "R8" : "R7";
         return e;
      end
      g0 = int'(a >> 4);
      tc = ((int'(a) & 15) + sz) / 16 + 1;   // R1
      n  = 0;
      while (n < tc) begin
         b  = tmem[((g0 + n) >> 1) & 63];
         nb = ((g0 + n) % 2 == 1) ? b[7:4] : b[3:0];  // R2 nibble layout
         if (nb != t) break;
         n++;
      end
      e.pass  = (n == tc);                  // R4
      e.count = CW'(n);
      e.fault = (n == 0) ? a : AW'(g0 * 16 + n * 16);  // R5 / R6
      lastg   = g0 + ((n < tc) ? n : tc - 1);
      e.reads = (lastg >> 1) - (g0 >> 1) + 1;
      e.rq    = (n == 0) ? "R5" : "R6";
      return e;
   endfunction

   // Monitor: pops the scoreboard on each result pulse.
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb_q.size() == 0) begin
            chk("R9", "unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            last_exp = e;
            chk("R4", "pass", res_pass, e.pass);
            chk("R4", "count", res_count, e.count);
            chk(e.rq, "fault address", res_fault_addr, e.fault);
            chk("R10", "write echo", res_write, e.wr);
            chk((e.rq == "R7" || e.rq == "R8") ? e.rq : "R2", "tag reads", rd_cnt, e.reads);
         end
         n_seen++;
      end
   end

   task automatic do_req(logic [AW-1:0] a, int sz, bit wr, bit en, bit all, logic [3:0] t);
      exp_t e;
      e = ref_walk(a, sz, wr, en, all, t);
      sb_q.push_back(e);
      n_sent++;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_addr = a; req_size_m1 = SW'(sz); req_write = wr;
      req_check_en = en; req_match_all = all; req_tag = t;
      req_valid = 1'b1;
      rd_cnt = 0;
      @(negedge clk);
      req_valid = 1'b0;
      while (n_seen < n_sent) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) tmem[i] = (i < 16) ? 8'hAA : 8'h55;
      repeat (3) @(negedge clk);
      chk("R9", "reset ready", req_ready, 1);
      chk("R9", "reset valid", res_valid, 0);
      chk("R2", "reset read strobe", tm_rd_en, 0);
      rst_n = 1'b1;
      @(negedge clk);

      do_req(32'h000, 15, 0, 1, 0, 4'hA);        // R1 aligned single granule
      do_req(32'h010, 31, 0, 1, 0, 4'hA);        // R3 odd start, two granules
      do_req(32'h00F, 1, 0, 1, 0, 4'hA);         // R1 two bytes straddle granule edge
      do_req(32'h034, 7, 0, 1, 0, 4'hB);         // R5 first-granule mismatch
      tmem[3] = 8'hCA;                           // granule 7 (high nibble) wrong
      do_req(32'h048, 63, 0, 1, 0, 4'hA);        // R6 later mismatch, high nibble
      do_req(32'h048, 63, 1, 1, 0, 4'hA);        // R10 same access as store
      tmem[5] = 8'hAC;                           // granule 10 (low nibble) wrong
      do_req(32'h090, 47, 0, 1, 0, 4'hA);        // R6 later mismatch, low nibble
      do_req(32'h100, 255, 0, 1, 0, 4'hA);       // R1 sixteen granules pass
      do_req(32'h108, 255, 0, 1, 0, 4'hA);       // R6 seventeenth granule fails
      do_req(32'h048, 63, 0, 0, 0, 4'h3);        // R7 check disabled
      do_req(32'h048, 63, 1, 1, 1, 4'h3);        // R8 match-all bypass

      // R9: result fields hold while idle.
      repeat (4) @(negedge clk);
      chk("R9", "held pass", res_pass, last_exp.pass);
      chk("R9", "held count", res_count, last_exp.count);
      chk("R9", "held fault", res_fault_addr, last_exp.fault);
      chk("R9", "valid low while idle", res_valid, 0);

      for (int i = 0; i < 64; i++) tmem[i] = (i % 7 == 3) ? 8'hA5 : 8'hAA;
      for (int i = 0; i < 40; i++) begin
         do_req(AW'((i * 37) % 1792), (i * 29) % 200, i[0], 1, 0, 4'hA);  // R3 R4 sweep
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule